// File: doc/BRIEF.md
# Latched-Address Inverting Line Decoder

The block turns a binary address into a set of active-low select lines, at most one of them low at a time. A small holding register sits in front of the decoder. While the hold input is low, the register reloads from the live address bus on every clock, and the decoder follows the bus. When the hold input rises, the register keeps its value, so the stored address can drive the selects while the bus carries other traffic.

Two gating inputs, one active low and one active high, act on the outputs directly. Unless both are at their active level, every select line is high. The gating does not touch the stored address. It takes effect in the same cycle, without waiting for a clock edge. A synchronous reset loads a stored address of zero.

Top module: `lad_decoder`

## Requirements
- R1: While `hold` is low at a rising clock edge, the stored address takes the value of `addr` at that edge, so `sel_n` follows `addr` with one cycle of latency.
- R2: On the first rising edge at which `hold` is seen high after having been low, the stored address still loads `addr`. On later edges with `hold` still high, it keeps its value, whatever `addr` does.
- R3: The outputs are enabled only when `en_lo_n` = 0 and `en_hi` = 1. For the other three combinations, all bits of `sel_n` are 1.
- R4: Changing `en_lo_n` or `en_hi` never changes the stored address. When the outputs are enabled again, they decode the same address as before.
- R5: While enabled, exactly one bit of `sel_n` is 0, and it is the bit whose index equals the stored address.
- R6: `addr[0]` is the least significant address bit, and output index i is `sel_n[i]`. For example, `addr` = 3'b001 drives `sel_n[1]` low, and `addr` = 3'b100 drives `sel_n[4]` low.
- R7: A high `rst` at a rising edge sets the stored address to 0 and marks `hold` as already high. If `hold` stays high after reset, the address stays 0. Reset does not bypass the R3 gating.
- R8: A change on the gating inputs appears on `sel_n` within the same clock cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the address register |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Live address bus |
| hold | input | 1 | Low: register tracks `addr`; high: register freezes |
| en_lo_n | input | 1 | Output gate, active low |
| en_hi | input | 1 | Output gate, active high |
| sel_n | output | 2**ADDR_W | Active-low select lines |

## Verification
A wrong stored address shows at the ports one cycle after the edge that loaded it, but only while the gates are enabled. The bench therefore keeps the gates enabled around every hold and capture check, and re-enables them after any gating sequence before it reads the address back. An error in the capture edge (one load too many or too few when `hold` rises) shows as a different low line on the cycle right after that edge. A gating error shows at once, within the same cycle, and is checked before the next clock edge.

// File: rtl/lad_pkg.sv
package lad_pkg;
  localparam int LAD_ADDR_W = 3;

  // Outputs are live only for the single active gate combination.
  function automatic logic gate_open(input logic lo_n, input logic hi);
    return (~lo_n) & hi;
  endfunction
endpackage

// File: rtl/lad_hold.sv
module lad_hold #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              hold,
  output logic [ADDR_W-1:0] held
);
  logic hold_q;

  // Load while transparent, and once more on the first edge that sees hold high.
  always_ff @(posedge clk) begin
    if (rst) begin
      held   <= '0;
      hold_q <= 1'b1;
    end else begin
      hold_q <= hold;
      if (!hold || !hold_q) held <= addr;
    end
  end
endmodule

// File: rtl/lad_onehot.sv
module lad_onehot #(
  parameter int ADDR_W = 3,
  localparam int OUT_N = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] held,
  output logic [OUT_N-1:0]  hot
);
  for (genvar i = 0; i < OUT_N; i++) begin : g_line
    assign hot[i] = (held == ADDR_W'(i));
  end
endmodule

// File: rtl/lad_gate.sv
module lad_gate #(
  parameter int OUT_N = 8
) (
  input  logic [OUT_N-1:0] hot,
  input  logic             en_lo_n,
  input  logic             en_hi,
  output logic [OUT_N-1:0] sel_n
);
  import lad_pkg::*;
  logic open_w;
  assign open_w = gate_open(en_lo_n, en_hi);

  for (genvar i = 0; i < OUT_N; i++) begin : g_drv
    assign sel_n[i] = ~(hot[i] & open_w);
  end
endmodule

// File: rtl/lad_decoder.sv
module lad_decoder #(
  parameter int ADDR_W = lad_pkg::LAD_ADDR_W,
  localparam int OUT_N = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              hold,
  input  logic              en_lo_n,
  input  logic              en_hi,
  output logic [OUT_N-1:0]  sel_n
);
  logic [ADDR_W-1:0] held_w;
  logic [OUT_N-1:0]  hot_w;

  lad_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk(clk), .rst(rst), .addr(addr), .hold(hold), .held(held_w)
  );

  lad_onehot #(.ADDR_W(ADDR_W)) u_dec (
    .held(held_w), .hot(hot_w)
  );

  lad_gate #(.OUT_N(OUT_N)) u_gate (
    .hot(hot_w), .en_lo_n(en_lo_n), .en_hi(en_hi), .sel_n(sel_n)
  );
endmodule

// File: rtl/lad_chk.sv
module lad_chk #(
  parameter int ADDR_W = 3,
  localparam int OUT_N = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              hold,
  input logic              en_lo_n,
  input logic              en_hi,
  input logic [OUT_N-1:0]  sel_n
);
  logic en_w;
  assign en_w = !en_lo_n && en_hi;

  // R1: transparent load shows one cycle later
  a_r1_follow: assert property (@(posedge clk) disable iff (rst)
    (!$past(hold) && !$past(rst) && en_w) |-> (sel_n == ~(OUT_N'(1) << $past(addr))));

  // R2: two consecutive high hold edges keep the outputs unchanged
  a_r2_freeze: assert property (@(posedge clk) disable iff (rst)
    (en_w && $past(en_w) && $past(hold) && $past(hold, 2) && !$past(rst)) |-> $stable(sel_n));

  // R3: closed gate drives every line high
  a_r3_gate_closed: assert property (@(posedge clk) disable iff (rst)
    !en_w |-> (&sel_n));

  // R5: exactly one active line while open
  a_r5_one_low: assert property (@(posedge clk) disable iff (rst)
    en_w |-> ($countones(~sel_n) == 1));

  // R7: reset selects line zero
  a_r7_reset_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && en_w) |-> (sel_n == ~OUT_N'(1)));
endmodule

bind lad_decoder lad_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .hold(hold),
  .en_lo_n(en_lo_n), .en_hi(en_hi), .sel_n(sel_n)
);

// File: tb/tb_lad_decoder.sv
module tb_lad_decoder;
  localparam int AW = 3;
  localparam int N  = 1 << AW;

  typedef struct {
    logic [N-1:0] exp;
    string        tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic hold = 1'b0;
  logic en_lo_n = 1'b0;
  logic en_hi = 1'b1;
  logic [N-1:0] sel_n;

  int total = 0;
  int bad = 0;
  item_t q[$];

  logic [AW-1:0] m_held = '0;
  logic          m_hq = 1'b1;

  always #5 clk = ~clk;

  lad_decoder #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .addr(addr), .hold(hold),
    .en_lo_n(en_lo_n), .en_hi(en_hi), .sel_n(sel_n)
  );

  function automatic logic [N-1:0] expect_sel(logic [AW-1:0] h, logic lo_n, logic hi);
    return (!lo_n && hi) ? ~(N'(1) << h) : {N{1'b1}};
  endfunction

  task automatic check(logic [N-1:0] act, logic [N-1:0] exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: sel_n=%b expected=%b", tag, act, exp);
    end
  endtask

  // Driver: apply inputs, check gating at once, queue the post-edge result.
  task automatic step(logic r, logic [AW-1:0] a, logic h, logic lo_n, logic hi, string tag);
    item_t it;
    @(negedge clk);
    rst = r; addr = a; hold = h; en_lo_n = lo_n; en_hi = hi;
    #1;
    check(sel_n, expect_sel(m_held, lo_n, hi), "R8");
    if (r) begin
      m_held = '0;
      m_hq   = 1'b1;
    end else begin
      if (!h || !m_hq) m_held = a;
      m_hq = h;
    end
    it.exp = expect_sel(m_held, lo_n, hi);
    it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(sel_n, it.exp, it.tag);
      end
    end
  end

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(1, 3'd5, 0, 0, 1, "R7");
    step(1, 3'd6, 0, 0, 1, "R7");
    step(0, 3'd0, 0, 0, 1, "R1");
    for (int i = 0; i < N; i++) step(0, AW'(i), 0, 0, 1, "R5");
    step(0, 3'd1, 0, 0, 1, "R6");
    step(0, 3'd4, 0, 0, 1, "R6");
    for (int e = 0; e < 4; e++) step(0, 3'd5, 0, e[0], e[1], "R3");
    step(0, 3'd6, 0, 0, 1, "R1");
    step(0, 3'd2, 1, 0, 1, "R2");
    step(0, 3'd7, 1, 0, 1, "R2");
    step(0, 3'd0, 1, 0, 1, "R2");
    step(0, 3'd4, 1, 0, 1, "R2");
    step(0, 3'd1, 1, 1, 1, "R4");
    step(0, 3'd3, 1, 1, 0, "R4");
    step(0, 3'd6, 1, 0, 0, "R4");
    step(0, 3'd5, 1, 0, 1, "R4");
    step(0, 3'd3, 0, 1, 0, "R3");
    step(0, 3'd3, 0, 0, 1, "R1");
    for (int a = 0; a < N; a++)
      for (int e = 0; e < 4; e++) step(0, AW'(a), 0, e[0], e[1], "R3");
    step(1, 3'd7, 1, 0, 1, "R7");
    step(0, 3'd5, 1, 0, 1, "R7");
    step(0, 3'd6, 1, 0, 1, "R7");
    step(0, 3'd6, 0, 0, 1, "R1");
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule